// File: doc/BRIEF.md
# Four-Input Rotating-Priority Leaf Arbiter

This block is the bottom cell of a tree-shaped fair arbiter. It watches four request lines and picks at most one of them each cycle. Four fixed-priority encoders, one for each rotation of the priority order, all work on the requests at the same time. A two-bit pointer register chooses which encoder's answer is used. The parent node answers the cell's upward request with an acknowledge. Only acknowledged selections leave the cell as grants, and only they move the pointer. The pointer is loaded with the index of the input that was just granted. That input drops to the bottom of the order, and the input one index below it moves to the top.

The cell also reports when its service round is finished. A round is finished when the input it is selecting has no pending requester at a lower index. That flag is called `lock`. While `lock` is high, the upward request is withheld, so the parent can move on to other leaves before it revisits this one. `lock` and the upward request are built from the local selection, not from the acknowledge. This keeps the parent handshake free of combinational loops.

The reset input is asynchronous and active-low. Its release is passed through two flip-flops inside the cell. While the cell is in reset, every output is held low.

Top module: `leaf_rr_arb`

## Requirements
- R1: While reset is active, `grant`, `lock` and `up_req` are all 0. After reset the pointer is 0, so input 3 has the highest priority.
- R2: Pointer value 0 orders the inputs 3,2,1,0. Value 1 orders them 0,3,2,1. Value 2 orders them 1,0,3,2. Value 3 orders them 2,1,0,3. In each case the first input listed has the highest priority. The selected input is the first requesting input in the order set by the current pointer.
- R3: `grant` is one-hot or zero. It never names an input whose request bit is 0, and it is 0 when `req` is 0.
- R4: When `ack` is 0, `grant` is 0 and the pointer does not change.
- R5: When `ack` is 1 and input i (`grant` bit i) is granted, the pointer takes the value i on the next clock edge.
- R6: `lock` is 1 exactly when the locally selected input i has no request on any input with an index below i. Input 0 always qualifies. `lock` does not depend on `ack`.
- R7: `up_req` is 1 when at least one request bit is set and `lock` is 0. Otherwise it is 0.
- R8: In a cycle with no grant, the pointer holds its value.
- R9: With all four inputs requesting and `ack` held at 1, the grants cycle through inputs 3,2,1,0 and then repeat. `lock` is 1 only on the grant to input 0.
- R10: When `rst_n` is released, the outputs stay low through the first rising clock edge. Arbitration starts after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the cell |
| req | input | 4 | Request lines; bit i is input i |
| ack | input | 1 | Acknowledge from the parent node |
| grant | output | 4 | One-hot acknowledged grant |
| up_req | output | 1 | Request toward the parent node |
| lock | output | 1 | Round-complete flag |

## Verification
The round-end flag and the pointer advance can fall in the same cycle. This happens when the input being granted is the lowest-indexed requester and `ack` is high. In that cycle the cell must raise `lock`, drop `up_req`, and still load the pointer with the granted index. The stimulus table provokes this several ways: with input 0 granted, with input 1 granted while input 0 is idle, and with input 3 alone. The cycle after each is judged by which input wins next. The table also raises `lock` with `ack` low. There the flag must appear while the pointer stays put, and the following acknowledged cycle confirms that.

// File: rtl/leaf_arb_pkg.sv
package leaf_arb_pkg;

  localparam int unsigned LEAF_NREQ = 4;

  // Index of the input at position k of the order whose top entry is 'top'.
  function automatic int unsigned order_pos(input int unsigned top,
                                            input int unsigned k,
                                            input int unsigned n);
    order_pos = (top + n - (k % n)) % n;
  endfunction

  // Top-priority input for a given pointer value.
  function automatic int unsigned top_of(input int unsigned ptr,
                                         input int unsigned n);
    top_of = (ptr + n - 1) % n;
  endfunction

endpackage

// File: rtl/leaf_rst_sync.sv
module leaf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/leaf_prio_enc.sv
module leaf_prio_enc
  import leaf_arb_pkg::*;
#(
  parameter int unsigned NREQ = LEAF_NREQ,
  parameter int unsigned TOP  = NREQ - 1
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt
);

  logic hit;

  // Scan downward from TOP, wrapping, and take the first requester.
  always_comb begin
    gnt = '0;
    hit = 1'b0;
    for (int unsigned k = 0; k < NREQ; k++) begin
      if (!hit && req[order_pos(TOP, k, NREQ)]) begin
        gnt[order_pos(TOP, k, NREQ)] = 1'b1;
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/leaf_lock_det.sv
module leaf_lock_det #(
  parameter int unsigned NREQ = 4
) (
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] sel,
  output logic            round_end
);

  logic [NREQ-1:0] term;

  // The selected input ends the round when nothing below it is pending.
  for (genvar i = 0; i < NREQ; i++) begin : g_term
    localparam logic [NREQ-1:0] BELOW = {NREQ{1'b1}} >> (NREQ - i);
    assign term[i] = sel[i] & ~(|(req & BELOW));
  end

  assign round_end = |term;

endmodule

// File: rtl/leaf_rr_arb.sv
module leaf_rr_arb
  import leaf_arb_pkg::*;
#(
  parameter int unsigned NREQ = LEAF_NREQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            ack,
  output logic [NREQ-1:0] grant,
  output logic            up_req,
  output logic            lock
);

  localparam int unsigned PW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic            rst_sync_n;
  logic [PW-1:0]   ptr_q;
  logic [PW-1:0]   ptr_d;
  logic            ptr_en;
  logic [NREQ-1:0] enc_g [NREQ];
  logic [NREQ-1:0] sel;
  logic            round_end;

  leaf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // One encoder per pointer value, all evaluated in parallel.
  for (genvar p = 0; p < NREQ; p++) begin : g_enc
    leaf_prio_enc #(
      .NREQ (NREQ),
      .TOP  (top_of(p, NREQ))
    ) u_enc (
      .req (req),
      .gnt (enc_g[p])
    );
  end

  // Output mux, steered by the registered pointer; held low in reset.
  always_comb begin
    sel = '0;
    if (rst_sync_n) begin
      sel = enc_g[ptr_q];
    end
  end

  leaf_lock_det #(.NREQ(NREQ)) u_lock (
    .req       (req),
    .sel       (sel),
    .round_end (round_end)
  );

  assign grant  = sel & {NREQ{ack}};
  assign lock   = round_end;
  assign up_req = rst_sync_n & (|req) & ~round_end;

  // Next pointer: index of the acknowledged grant.
  always_comb begin
    ptr_en = |grant;
    ptr_d  = ptr_q;
    for (int unsigned i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        ptr_d = PW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));  // R3
  AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (grant & ~req) == '0);  // R3
  AST_NO_ACK_NO_GNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ack |-> grant == '0);  // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grant == '0 |=> $stable(ptr_q));  // R8
  AST_UPREQ_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    up_req |-> |req);  // R7

  for (genvar i = 0; i < NREQ; i++) begin : g_ast_load
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
      grant[i] |=> ptr_q == PW'(i));  // R5
  end

endmodule

// File: tb/leaf_rr_arb_tb_top.sv
`timescale 1ns/1ps
module leaf_rr_arb_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic       ack;
  logic [3:0] grant;
  logic       up_req;
  logic       lock;

  int total;
  int bad;
  bit done;

  leaf_rr_arb dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .ack    (ack),
    .grant  (grant),
    .up_req (up_req),
    .lock   (lock)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req[3:0], ack, exp_grant[3:0], exp_lock, exp_up}; starts at pointer 0.
  localparam int NV = 16;
  localparam logic [10:0] VEC [NV] = '{
    {4'b0101, 1'b1, 4'b0100, 1'b0, 1'b1},  // R2 ptr0, R5 -> ptr2
    {4'b0101, 1'b1, 4'b0001, 1'b1, 1'b0},  // R2 ptr2, R6 lock on input 0
    {4'b0101, 1'b0, 4'b0000, 1'b0, 1'b1},  // R4 no ack, ptr stays 0
    {4'b0000, 1'b1, 4'b0000, 1'b0, 1'b0},  // R3 no request
    {4'b1111, 1'b1, 4'b1000, 1'b0, 1'b1},  // R9 step 3
    {4'b1111, 1'b1, 4'b0100, 1'b0, 1'b1},  // R9 step 2
    {4'b1111, 1'b1, 4'b0010, 1'b0, 1'b1},  // R9 step 1
    {4'b1111, 1'b1, 4'b0001, 1'b1, 1'b0},  // R9 step 0 with lock
    {4'b1010, 1'b1, 4'b1000, 1'b0, 1'b1},  // R6 lower request pending
    {4'b1010, 1'b1, 4'b0010, 1'b1, 1'b0},  // R6 input 1, input 0 idle
    {4'b1010, 1'b1, 4'b1000, 1'b0, 1'b1},  // R2 ptr1 order 0,3,2,1
    {4'b1000, 1'b1, 4'b1000, 1'b1, 1'b0},  // R6 input 3 alone
    {4'b0010, 1'b0, 4'b0000, 1'b1, 1'b0},  // R6 lock without ack, R4
    {4'b0011, 1'b1, 4'b0010, 1'b0, 1'b1},  // R4 ptr held at 3, R7
    {4'b0011, 1'b1, 4'b0001, 1'b1, 1'b0},  // R5 ptr1 after input 1
    {4'b0011, 1'b1, 4'b0010, 1'b0, 1'b1}   // R5 ptr0 after input 0
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [3:0] eg,
                           input logic el, input logic eu);
    check({tag, " grant"}, grant, eg);
    check({tag, " lock"}, {3'b0, lock}, {3'b0, el});
    check({tag, " up_req"}, {3'b0, up_req}, {3'b0, eu});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    req   = 4'b0000;
    ack   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = 4'b1111;
    ack = 1'b1;
    #1 check_all("R1 in reset", 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_all("R10 one edge after release", 4'b0000, 1'b0, 1'b0);
    @(posedge clk);

    // Stimulus table.
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req = VEC[v][10:7];
      ack = VEC[v][6];
      #1 check_all($sformatf("R2/R5/R6/R7 vec%0d", v), VEC[v][5:2], VEC[v][1], VEC[v][0]);
    end

    // Pointer is now 1; async reset mid-run.
    @(negedge clk);
    req   = 4'b1111;
    ack   = 1'b1;
    rst_n = 1'b0;
    #1 check_all("R1 async assert", 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_all("R10 held after release", 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    #1 check_all("R10 still held first edge", 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    #1 check_all("R1 pointer 0 after reset", 4'b1000, 1'b0, 1'b1);

    // Pointer now 3; hold with no ack for several cycles.
    @(negedge clk);
    ack = 1'b0;
    #1 check("R4 no grant without ack", grant, 4'b0000);
    repeat (3) @(negedge clk);
    #1 check("R8 idle no grant", grant, 4'b0000);
    ack = 1'b1;
    #1 check("R8 pointer held at 3", grant, 4'b0100);

    // Single requester at input 0 from pointer 2.
    @(negedge clk);
    req = 4'b0001;
    #1 check_all("R6 input 0 alone", 4'b0001, 1'b1, 1'b0);
    @(negedge clk);
    req = 4'b0000;
    #1 check_all("R3 idle after round", 4'b0000, 1'b0, 1'b0);

    finish_run();
  end

endmodule